// File: doc/BRIEF.md
# Regulator voltage scale controller

This block picks the voltage scale that the main core regulator applies. It also sequences the request to raise the core supply into over-drive and the later request to switch the core logic onto it. Software-visible control bits arrive as plain levels and a write strobe. The block reports a ready flag for the applied scale, one for over-drive and one for the over-drive switch. It also reports a code for the highest core frequency that the applied scale allows.

A scale value can only be loaded while the PLL is stopped, which is when the system runs from a plain oscillator. The loaded value reaches the regulator only while the PLL runs. While the PLL is stopped, the lowest scale is applied. The analog regulator's settling is modelled by a counter of `SETTLE_CYC` clock cycles. An external `vreg_ok` level from the regulator model qualifies every ready flag. All pins are plain control and status levels. No port carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `vscale_ctrl`

## Requirements
- R1: After reset, `vos_out` is 01, `freq_cls` is 0, and `scale_err`, `od_rdy` and `odsw_rdy` are 0. The programmed scale is 11. `vos_rdy` is 0 and rises at the `SETTLE_CYC`-th clock edge after reset release.
- R2: The 2-bit scale code is 11 for scale 1 (fastest), 10 for scale 2 and 01 for scale 3. A write of 00 is ignored and leaves both the programmed scale and `scale_err` unchanged. `freq_cls` is 2 for scale 1 (168 MHz), 1 for scale 2 (144 MHz) and 0 for scale 3 (120 MHz).
- R3: If `pll_on` is 0 at a clock edge, `vos_out` is 01 after that edge. If `pll_on` is 1 at a clock edge, `vos_out` shows the programmed scale after that edge.
- R4: A `scale_wr` pulse taken while `pll_on` is 1 leaves the programmed scale unchanged and sets `scale_err`. `scale_err` stays set until a write of a legal code is accepted while `pll_on` is 0.
- R5: When `vos_out` changes at a clock edge, `vos_rdy` is 0 after that edge and rises at the `SETTLE_CYC`-th edge after it.
- R6: A rising `od_req` taken at an edge makes `od_rdy` rise `SETTLE_CYC` edges later. When `od_req` is 0 at an edge, both `od_rdy` and `odsw_rdy` are 0 after it.
- R7: `odsw_req` has no effect until `od_rdy` is 1. The first edge that sees both `odsw_req` and `od_rdy` at 1 starts the switch settle, and `odsw_rdy` rises `SETTLE_CYC` edges after that edge. When `odsw_req` is 0 at an edge, `odsw_rdy` is 0 after it and `od_rdy` is kept.
- R8: While `vreg_ok` is 0, all three ready flags read 0 without delay. The settle counters are not disturbed, so the flags come back as soon as `vreg_ok` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scale_wr | input | 1 | One-cycle strobe to load `scale_wdata` |
| scale_wdata | input | 2 | Requested scale code |
| od_req | input | 1 | Over-drive enable level |
| odsw_req | input | 1 | Over-drive switch enable level |
| pll_on | input | 1 | PLL running indication |
| vreg_ok | input | 1 | Regulator model ready level |
| vos_out | output | 2 | Scale applied to the regulator |
| vos_rdy | output | 1 | Applied scale has settled |
| od_rdy | output | 1 | Over-drive has settled |
| odsw_rdy | output | 1 | Over-drive switch has settled |
| freq_cls | output | 2 | Maximum frequency class of the applied scale |
| scale_err | output | 1 | Sticky flag for a scale write refused while the PLL runs |

## Verification
The scale path is driven with writes of every code, each made with the PLL both stopped and running. This separates accepted writes, writes refused because the PLL runs, and the reserved code that must leave even the error flag alone. After each write the PLL is started, so the applied scale and the frequency class show which value was retained. The over-drive path is tried with several orderings: both enables raised together, the switch enable dropped and raised again with over-drive settled, the switch enable held while over-drive is off, and the regulator-ready level pulled low. These tell whether the switch waits for over-drive, whether each enable clears only its own flags, and whether the counters survive a masked ready.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

  typedef enum logic [1:0] {
    VS_RSVD = 2'b00,
    VS_LOW  = 2'b01,
    VS_MID  = 2'b10,
    VS_HIGH = 2'b11
  } vscale_e;

  localparam vscale_e VS_AT_RESET = VS_HIGH;
  localparam vscale_e VS_PLL_OFF  = VS_LOW;

  function automatic logic [1:0] freq_class(input vscale_e s);
    case (s)
      VS_HIGH: freq_class = 2'd2;
      VS_MID:  freq_class = 2'd1;
      default: freq_class = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/vsc_settle.sv
module vsc_settle #(
  parameter int unsigned SETTLE_CYC    = 8,
  parameter bit          BUSY_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic done
);
  localparam int unsigned CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= BUSY_AT_RESET ? LOAD : '0;
      busy_q <= BUSY_AT_RESET;
      done_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= LOAD;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (abort) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign done = done_q;

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);  // R5
  AST_ABORT_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start) |=> !done);  // R6
  AST_DONE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy_q));  // R5

endmodule

// File: rtl/vsc_scale.sv
module vsc_scale
  import vsc_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  input  logic       pll_on,
  output vscale_e    eff,
  output logic       err,
  output logic       settled
);
  vscale_e prog_q;
  vscale_e eff_q;
  vscale_e eff_nxt;
  logic    err_q;
  logic    eff_chg;
  logic    accept;

  assign accept = wr && !pll_on && (wdata != VS_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= VS_AT_RESET;
      err_q  <= 1'b0;
    end else if (wr) begin
      if (pll_on) begin
        err_q <= 1'b1;
      end else if (accept) begin
        prog_q <= vscale_e'(wdata);
        err_q  <= 1'b0;
      end
    end
  end

  assign eff_nxt = pll_on ? prog_q : VS_PLL_OFF;
  assign eff_chg = (eff_nxt != eff_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_q <= VS_PLL_OFF;
    else        eff_q <= eff_nxt;
  end

  vsc_settle #(
    .SETTLE_CYC   (SETTLE_CYC),
    .BUSY_AT_RESET(1'b1)
  ) i_settle (
    .clk  (clk),
    .rst_n(rst_n),
    .start(eff_chg),
    .abort(1'b0),
    .done (settled)
  );

  assign eff = eff_q;
  assign err = err_q;

  AST_PROG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    prog_q != VS_RSVD);  // R2
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && pll_on) |=> ($stable(prog_q) && err_q));  // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !accept) |=> err_q);  // R4
  AST_LOW_WHEN_PLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_on |=> (eff == VS_LOW));  // R3

endmodule

// File: rtl/vsc_overdrive.sv
module vsc_overdrive #(
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic od_req,
  input  logic sw_req,
  output logic od_done,
  output logic sw_done
);
  logic od_arm_q;
  logic sw_arm_q;
  logic od_start;
  logic od_abort;
  logic sw_start;
  logic sw_abort;

  assign od_start = od_req && !od_arm_q;
  assign od_abort = !od_req;
  assign sw_start = sw_req && od_req && od_done && !sw_arm_q;
  assign sw_abort = !sw_req || !od_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_arm_q <= 1'b0;
      sw_arm_q <= 1'b0;
    end else begin
      od_arm_q <= od_req;
      sw_arm_q <= sw_arm_q ? (sw_req && od_req) : sw_start;
    end
  end

  vsc_settle #(
    .SETTLE_CYC   (SETTLE_CYC),
    .BUSY_AT_RESET(1'b0)
  ) i_od_settle (
    .clk  (clk),
    .rst_n(rst_n),
    .start(od_start),
    .abort(od_abort),
    .done (od_done)
  );

  vsc_settle #(
    .SETTLE_CYC   (SETTLE_CYC),
    .BUSY_AT_RESET(1'b0)
  ) i_sw_settle (
    .clk  (clk),
    .rst_n(rst_n),
    .start(sw_start),
    .abort(sw_abort),
    .done (sw_done)
  );

  AST_SW_NEEDS_OD: assert property (@(posedge clk) disable iff (!rst_n)
    sw_done |-> od_done);  // R7
  AST_OD_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !od_req |=> (!od_done && !sw_done));  // R6
  AST_SW_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_req |=> !sw_done);  // R7

endmodule

// File: rtl/vscale_ctrl.sv
module vscale_ctrl
  import vsc_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scale_wr,
  input  logic [1:0] scale_wdata,
  input  logic       od_req,
  input  logic       odsw_req,
  input  logic       pll_on,
  input  logic       vreg_ok,
  output logic [1:0] vos_out,
  output logic       vos_rdy,
  output logic       od_rdy,
  output logic       odsw_rdy,
  output logic [1:0] freq_cls,
  output logic       scale_err
);
  vscale_e eff;
  logic    scale_settled;
  logic    od_done;
  logic    sw_done;

  vsc_scale #(.SETTLE_CYC(SETTLE_CYC)) i_scale (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (scale_wr),
    .wdata  (scale_wdata),
    .pll_on (pll_on),
    .eff    (eff),
    .err    (scale_err),
    .settled(scale_settled)
  );

  vsc_overdrive #(.SETTLE_CYC(SETTLE_CYC)) i_od (
    .clk    (clk),
    .rst_n  (rst_n),
    .od_req (od_req),
    .sw_req (odsw_req),
    .od_done(od_done),
    .sw_done(sw_done)
  );

  assign vos_out  = eff;
  assign freq_cls = freq_class(eff);
  assign vos_rdy  = scale_settled && vreg_ok;
  assign od_rdy   = od_done && vreg_ok;
  assign odsw_rdy = sw_done && vreg_ok;

  AST_VOS_CHANGE_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    (vos_out != $past(vos_out)) |-> !vos_rdy);  // R5
  AST_CLASS_NONZERO_ON_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_cls != 2'd0) |-> $past(pll_on));  // R3

endmodule

// File: tb/test_vscale_ctrl.sv
`timescale 1ns/1ps
module test_vscale_ctrl;
  localparam int S = 5;
  localparam int NV = 8;
  // fields: {pll_during_write, wdata[1:0], exp_vos[1:0], exp_err, exp_cls[1:0]}
  localparam logic [7:0] VEC [NV] = '{
    {1'b0, 2'b10, 2'b10, 1'b0, 2'd1},
    {1'b1, 2'b11, 2'b10, 1'b1, 2'd1},
    {1'b0, 2'b01, 2'b01, 1'b0, 2'd0},
    {1'b0, 2'b00, 2'b01, 1'b0, 2'd0},
    {1'b0, 2'b11, 2'b11, 1'b0, 2'd2},
    {1'b1, 2'b10, 2'b11, 1'b1, 2'd2},
    {1'b0, 2'b00, 2'b11, 1'b1, 2'd2},
    {1'b0, 2'b10, 2'b10, 1'b0, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scale_wr = 1'b0;
  logic [1:0] scale_wdata = 2'b00;
  logic od_req = 1'b0;
  logic odsw_req = 1'b0;
  logic pll_on = 1'b0;
  logic vreg_ok = 1'b1;
  logic [1:0] vos_out;
  logic vos_rdy;
  logic od_rdy;
  logic odsw_rdy;
  logic [1:0] freq_cls;
  logic scale_err;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  vscale_ctrl #(.SETTLE_CYC(S)) i_vscale_ctrl (
    .clk(clk), .rst_n(rst_n), .scale_wr(scale_wr), .scale_wdata(scale_wdata),
    .od_req(od_req), .odsw_req(odsw_req), .pll_on(pll_on), .vreg_ok(vreg_ok),
    .vos_out(vos_out), .vos_rdy(vos_rdy), .od_rdy(od_rdy), .odsw_rdy(odsw_rdy),
    .freq_cls(freq_cls), .scale_err(scale_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    #0.5;
    // R1 reset state
    chk("R1 vos_out", vos_out, 1);
    chk("R1 freq_cls", freq_cls, 0);
    chk("R1 scale_err", scale_err, 0);
    chk("R1 od_rdy", od_rdy, 0);
    chk("R1 odsw_rdy", odsw_rdy, 0);
    chk("R1 vos_rdy low", vos_rdy, 0);
    cyc(S - 1);
    chk("R1 vos_rdy before settle", vos_rdy, 0);
    cyc(1);
    chk("R1 vos_rdy settled", vos_rdy, 1);

    // R1: reset programmed scale is 11, seen once the PLL runs
    pll_on = 1'b1;
    cyc(S + 2);
    chk("R1 programmed scale", vos_out, 3);

    // R2 R3 R4 vector table
    for (int i = 0; i < NV; i++) begin
      pll_on = VEC[i][7];
      cyc(2);
      if (!VEC[i][7]) chk("R3 scale3 while pll off", vos_out, 1);
      scale_wr = 1'b1;
      scale_wdata = VEC[i][6:5];
      cyc(1);
      scale_wr = 1'b0;
      pll_on = 1'b1;
      cyc(S + 2);
      chk("R2 R3 applied scale", vos_out, VEC[i][4:3]);
      chk("R4 scale_err", scale_err, VEC[i][2]);
      chk("R2 freq_cls", freq_cls, VEC[i][1:0]);
      chk("R5 vos_rdy settled", vos_rdy, 1);
    end

    // R5 settle timing on pll start
    pll_on = 1'b0;
    cyc(S + 3);
    pll_on = 1'b1;
    cyc(1);
    chk("R3 scale follows pll", vos_out, 2);
    chk("R5 rdy drops", vos_rdy, 0);
    cyc(S - 1);
    chk("R5 rdy still low", vos_rdy, 0);
    cyc(1);
    chk("R5 rdy after settle", vos_rdy, 1);

    // R6 R7 both enables together
    od_req = 1'b1;
    odsw_req = 1'b1;
    cyc(S);
    chk("R6 od_rdy early", od_rdy, 0);
    cyc(1);
    chk("R6 od_rdy settled", od_rdy, 1);
    chk("R7 switch waits", odsw_rdy, 0);
    cyc(S);
    chk("R7 odsw_rdy early", odsw_rdy, 0);
    cyc(1);
    chk("R7 odsw_rdy settled", odsw_rdy, 1);

    // R8 regulator not ready masks flags
    vreg_ok = 1'b0;
    #1;
    chk("R8 vos_rdy masked", vos_rdy, 0);
    chk("R8 od_rdy masked", od_rdy, 0);
    chk("R8 odsw_rdy masked", odsw_rdy, 0);
    vreg_ok = 1'b1;
    #1;
    chk("R8 vos_rdy back", vos_rdy, 1);
    chk("R8 od_rdy back", od_rdy, 1);
    chk("R8 odsw_rdy back", odsw_rdy, 1);

    // R7 switch enable drop and re-raise
    odsw_req = 1'b0;
    cyc(1);
    chk("R7 odsw_rdy drops", odsw_rdy, 0);
    chk("R7 od_rdy kept", od_rdy, 1);
    odsw_req = 1'b1;
    cyc(S);
    chk("R7 odsw_rdy early", odsw_rdy, 0);
    cyc(1);
    chk("R7 odsw_rdy resettled", odsw_rdy, 1);

    // R6 over-drive drop clears both
    od_req = 1'b0;
    cyc(1);
    chk("R6 od_rdy drops", od_rdy, 0);
    chk("R6 odsw_rdy drops", odsw_rdy, 0);
    cyc(S + 3);
    chk("R7 switch ignored without od", odsw_rdy, 0);
    od_req = 1'b1;
    cyc(S + 1);
    chk("R6 od_rdy again", od_rdy, 1);
    chk("R7 switch still waiting", odsw_rdy, 0);
    cyc(S + 1);
    chk("R7 odsw_rdy after od", odsw_rdy, 1);

    finish_run();
  end
endmodule